// File: doc/BRIEF.md
# Manchester Clock Recovery by Edge-Interval Counting

This block takes a Manchester-coded line, oversamples it with the fast system clock and measures the time between transitions with a counter. It uses that interval to tell mid-bit transitions from transitions at bit boundaries. From the mid-bit transitions it rebuilds the encoder's bit clock. Each rising edge of the rebuilt clock is launched on the same cycle that an accepted transition is seen. The clock is therefore phase-locked to the received waveform and can be wired straight to an instrument's external trigger, for example to hold an eye diagram steady.

The block also recovers the data bit behind each accepted transition. It raises a lock flag once the transition spacing has stayed close to the nominal bit period for a run of bits. The nominal bit period is a parameter counted in system clock cycles. It should be a multiple of four and at least 16.

In the line code a data 1 is high in the first half of the bit and low in the second half. A data 0 is low in the first half and high in the second. Analog slicing happens outside the block, and the input is already a clean logic level.

Top module: `manchester_clk_recover`

## Requirements
- R1: The line input passes through two synchronizing flip-flops. When an accepted transition is driven just after rising clock edge P0, `rec_clk_o` is still low after edge P2 and high after edge P3.
- R2: A transition is accepted as mid-bit only if more than 3/4 of `BIT_CYC` cycles have passed since the last accepted transition. Earlier transitions are ignored and produce no recovered clock pulse, so every data bit sent yields exactly one pulse.
- R3: `rec_data_o` takes, at each accepted transition, the line level seen `BIT_CYC/4` cycles earlier. This is the first-half level, so 1 means high-then-low. The output changes at no other time.
- R4: `rec_clk_o` rises on each accepted transition and stays high for exactly `BIT_CYC/2` cycles, which gives a 50% duty cycle at the nominal rate.
- R5: `lock_o` rises when the interval between accepted transitions has fallen within `BIT_CYC` ± `BIT_CYC/4` cycles (bounds included) `LOCK_RUN` times in a row.
- R6: An accepted transition whose interval lies outside that window restarts the run. A line running at a period of 22 cycles, with `BIT_CYC`=16, never locks but is still decoded.
- R7: When `3*BIT_CYC/2` cycles pass with no accepted transition, `lock_o` clears and the run count restarts. `lock_o` is still set 15 cycles after the last accepted transition.
- R8: While reset is asserted and just after it is released, `rec_clk_o`, `rec_data_o` and `lock_o` are all low.
- R9: After reset or a timeout, the first transition is accepted whatever its spacing. Its interval does not count toward lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| manch_i | input | 1 | Manchester-coded line level, asynchronous to clk |
| rec_clk_o | output | 1 | Recovered bit clock, rising on each accepted mid-bit transition |
| rec_data_o | output | 1 | Recovered data bit, updated with each recovered clock rise |
| lock_o | output | 1 | Set after a run of well-spaced mid-bit transitions, cleared on timeout |

## Verification
The embedded properties assume a line whose transitions are at least a few cycles apart. They also assume a half bit of at least five cycles, so the quarter-bit sample falls inside the first half. The stimulus always starts a burst from a low idle line with a 0 bit and ends it with a 1 bit. As a result the first transition of every burst is a mid-bit transition and the line returns low before each idle gap. Bursts run at the nominal period, at the upper window bound and just outside it. Random data is mixed in so that boundary transitions appear between equal bits.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

  // Transition report passed from the input stage to the rest of the block.
  typedef struct packed {
    logic hit;    // synchronized line changed level this cycle
    logic prior;  // synchronized level a quarter bit ago
  } mcr_edge_t;

  function automatic int unsigned cnt_bits(input int unsigned maxv);
    return $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/mcr_sync.sv
module mcr_sync #(
  parameter int unsigned QTR = 4
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               line_i,
  output mcr_pkg::mcr_edge_t edge_o
);

  logic           meta_q, lvl_q, lvl_d_q;
  logic [QTR-1:0] hist_q, hist_d;

  generate
    if (QTR == 1) begin : g_hist_one
      always_comb hist_d = lvl_q;
    end else begin : g_hist_many
      always_comb hist_d = {hist_q[QTR-2:0], lvl_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q  <= 1'b0;
      lvl_q   <= 1'b0;
      lvl_d_q <= 1'b0;
      hist_q  <= '0;
    end else begin
      meta_q  <= line_i;
      lvl_q   <= meta_q;
      lvl_d_q <= lvl_q;
      hist_q  <= hist_d;
    end
  end

  assign edge_o = '{hit: lvl_q ^ lvl_d_q, prior: hist_q[QTR-1]};

  // R1
  sync_two_stage_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(lvl_q) |-> $past(meta_q));

endmodule

// File: rtl/mcr_interval.sv
module mcr_interval #(
  parameter int unsigned BIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic hit_i,
  output logic accept_o,
  output logic good_o,
  output logic expired_o
);

  localparam int unsigned TO    = (3 * BIT_CYC) / 2;
  localparam int unsigned THR   = (3 * BIT_CYC) / 4;
  localparam int unsigned LO    = BIT_CYC - BIT_CYC / 4;
  localparam int unsigned HI    = BIT_CYC + BIT_CYC / 4;
  localparam int unsigned CNT_W = mcr_pkg::cnt_bits(TO);

  localparam logic [CNT_W-1:0] TO_C  = CNT_W'(TO);
  localparam logic [CNT_W-1:0] THR_C = CNT_W'(THR);
  localparam logic [CNT_W-1:0] LO_C  = CNT_W'(LO);
  localparam logic [CNT_W-1:0] HI_C  = CNT_W'(HI);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  // Cycles since the last accepted transition, saturating at the timeout.
  always_comb begin
    accept_o  = hit_i && (cnt_q > THR_C);
    good_o    = (cnt_q >= LO_C) && (cnt_q <= HI_C);
    expired_o = (cnt_q >= TO_C);
    cnt_en    = accept_o || !expired_o;
    cnt_d     = accept_o ? CNT_W'(1) : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= TO_C;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  accept_spacing_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept_o |=> !accept_o);

  // R9
  first_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (expired_o && hit_i) |-> !good_o);

endmodule

// File: rtl/mcr_lock.sv
module mcr_lock #(
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic good_i,
  input  logic expired_i,
  output logic lock_o
);

  localparam int unsigned RUN_W = mcr_pkg::cnt_bits(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  logic [RUN_W-1:0] run_q, run_d;
  logic             lock_q, lock_d;
  logic             upd_en;

  always_comb begin
    upd_en = expired_i || accept_i;
    run_d  = run_q;
    lock_d = lock_q;
    if (expired_i) begin
      run_d  = '0;
      lock_d = 1'b0;
    end else if (accept_i) begin
      if (good_i) begin
        run_d  = (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
        lock_d = lock_q || (run_q >= RUN_LAST);
      end else begin
        run_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      run_q  <= run_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q;

  // R5
  lock_on_good_edge_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(accept_i && good_i));

  // R7
  lock_timeout_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    expired_i |=> !lock_o);

endmodule

// File: rtl/mcr_clkgen.sv
module mcr_clkgen #(
  parameter int unsigned HALF = 8
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic accept_i,
  input  logic prior_i,
  output logic rclk_o,
  output logic rdata_o
);

  localparam int unsigned PH_W = mcr_pkg::cnt_bits(HALF);
  localparam logic [PH_W-1:0] PH_END = PH_W'(HALF);

  logic [PH_W-1:0] ph_q, ph_d;
  logic            rclk_q, rclk_d;
  logic            data_q;
  logic            ph_en;

  always_comb begin
    ph_en  = accept_i || rclk_q;
    ph_d   = ph_q;
    rclk_d = rclk_q;
    if (accept_i) begin
      ph_d   = PH_W'(1);
      rclk_d = 1'b1;
    end else if (ph_q == PH_END) begin
      rclk_d = 1'b0;
    end else begin
      ph_d   = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      rclk_q <= 1'b0;
    end else if (ph_en) begin
      ph_q   <= ph_d;
      rclk_q <= rclk_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
    end else if (accept_i) begin
      data_q <= prior_i;
    end
  end

  assign rclk_o  = rclk_q;
  assign rdata_o = data_q;

  // R4
  rise_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept_i |=> rclk_o);

  // R4
  rise_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(rclk_o) |-> $past(accept_i));

  // R3
  data_moves_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(rdata_o) |-> $past(accept_i));

endmodule

// File: rtl/manchester_clk_recover.sv
module manchester_clk_recover #(
  parameter int unsigned BIT_CYC  = 16,
  parameter int unsigned LOCK_RUN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic manch_i,
  output logic rec_clk_o,
  output logic rec_data_o,
  output logic lock_o
);

  localparam int unsigned HALF = BIT_CYC / 2;
  localparam int unsigned QTR  = BIT_CYC / 4;

  logic               rs_q1, rs_q2;
  logic               rst_ni;
  mcr_pkg::mcr_edge_t edge_w;
  logic               accept_w, good_w, expired_w;

  // Reset asserts at once and leaves on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_ni = rs_q2;

  mcr_sync #(.QTR(QTR)) u_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .line_i (manch_i),
    .edge_o (edge_w)
  );

  mcr_interval #(.BIT_CYC(BIT_CYC)) u_interval (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .hit_i     (edge_w.hit),
    .accept_o  (accept_w),
    .good_o    (good_w),
    .expired_o (expired_w)
  );

  mcr_lock #(.LOCK_RUN(LOCK_RUN)) u_lock (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .accept_i  (accept_w),
    .good_i    (good_w),
    .expired_i (expired_w),
    .lock_o    (lock_o)
  );

  mcr_clkgen #(.HALF(HALF)) u_clkgen (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .accept_i (accept_w),
    .prior_i  (edge_w.prior),
    .rclk_o   (rec_clk_o),
    .rdata_o  (rec_data_o)
  );

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_ni |=> (!rec_clk_o && !lock_o) || rst_ni);

endmodule

// File: tb/manchester_clk_recover_tb.sv
module manchester_clk_recover_tb;

  localparam int BIT_CYC = 16;
  localparam int HALF    = BIT_CYC / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic manch_i = 1'b0;
  logic rec_clk_o, rec_data_o, lock_o;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int pushed = 0;
  bit done = 1'b0;
  bit exp_q[$];
  logic [7:0] lfsr = 8'hA5;

  always #5 clk = ~clk;

  manchester_clk_recover #(.BIT_CYC(BIT_CYC), .LOCK_RUN(8)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .manch_i    (manch_i),
    .rec_clk_o  (rec_clk_o),
    .rec_data_o (rec_data_o),
    .lock_o     (lock_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Driver: one Manchester bit with a given half period; pushes the expected bit.
  task automatic send_bit(input bit b, input int half);
    exp_q.push_back(b);
    pushed++;
    @(posedge clk); #1 manch_i = b;
    repeat (half - 1) @(posedge clk);
    @(posedge clk); #1 manch_i = ~b;
    repeat (3) @(negedge clk);
    chk(rec_clk_o == 1'b0, "R1", "clock before third edge", rec_clk_o, 0);
    @(negedge clk);
    chk(rec_clk_o == 1'b1, "R1", "clock after third edge", rec_clk_o, 1);
    repeat (half - 4) @(posedge clk);
  endtask

  function automatic bit next_rand();
    logic fb;
    fb   = lfsr[7] ^ lfsr[3] ^ lfsr[2] ^ lfsr[1];
    lfsr = {lfsr[6:0], fb};
    return lfsr[7];
  endfunction

  // Monitor: pops one expected bit per recovered clock rise, checks pulse width.
  initial begin
    logic prev_clk;
    int   width;
    prev_clk = 1'b0;
    width    = 0;
    forever begin
      @(negedge clk);
      if (rec_clk_o && !prev_clk) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "extra clock pulse", pulses, pushed);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(rec_data_o == e, "R3", "recovered data", rec_data_o, e);
        end
        width = 1;
      end else if (rec_clk_o) begin
        width++;
      end else if (prev_clk) begin
        chk(width == HALF, "R4", "clock high width", width, HALF);
      end
      prev_clk = rec_clk_o;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: outputs quiet during reset
    chk({rec_clk_o, rec_data_o, lock_o} == 3'b000, "R8", "outputs in reset",
        {rec_clk_o, rec_data_o, lock_o}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({rec_clk_o, rec_data_o, lock_o} == 3'b000, "R8", "outputs after reset",
        {rec_clk_o, rec_data_o, lock_o}, 0);

    // Burst A: nominal period; first edge taken at once (R9), lock after 8 good intervals (R5)
    for (int i = 1; i <= 12; i++) begin
      send_bit(i[0] ? 1'b0 : 1'b1, HALF);
      chk(lock_o == (i >= 9), "R5", "lock after bit count", lock_o, (i >= 9));
    end
    // Random data: boundary transitions appear between equal bits (R2)
    for (int i = 0; i < 40; i++) send_bit(next_rand(), HALF);
    send_bit(1'b1, HALF);
    chk(lock_o == 1'b1, "R5", "lock held on random data", lock_o, 1);

    // R7: lock survives a short gap, clears after 1.5 bit periods
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(lock_o == 1'b1, "R7", "lock before timeout", lock_o, 1);
    repeat (20) @(negedge clk);
    chk(lock_o == 1'b0, "R7", "lock after timeout", lock_o, 0);
    chk(rec_clk_o == 1'b0, "R4", "clock idle low", rec_clk_o, 0);

    // Burst B: period 22 lies outside the window, never locks but decodes (R6)
    for (int i = 1; i <= 14; i++) begin
      send_bit(i[0] ? 1'b0 : 1'b1, 11);
      chk(lock_o == 1'b0, "R6", "no lock off window", lock_o, 0);
    end
    send_bit(1'b1, 11);
    repeat (40) @(posedge clk);

    // Burst C: period 20 sits on the window bound and locks (R5, R9)
    for (int i = 1; i <= 10; i++) begin
      send_bit(i[0] ? 1'b0 : 1'b1, 10);
      chk(lock_o == (i >= 9), "R5", "lock at window bound", lock_o, (i >= 9));
    end
    for (int i = 0; i < 20; i++) send_bit(next_rand(), 10);
    send_bit(1'b1, 10);
    repeat (40) @(negedge clk);

    // R2: exactly one pulse per bit, boundary transitions ignored
    chk(pulses == pushed, "R2", "pulse count", pulses, pushed);
    chk(exp_q.size() == 0, "R2", "bits left unmatched", exp_q.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule